// File: doc/BRIEF.md
# Video Controller Command Port Latch

This block sits between a host bus and a video display processor. It decodes host reads and writes to the processor's port window, which holds a data port, a control port and a beam position counter port. Control-port writes are sorted into single-word register writes and two-word command sequences. The block holds the first word of a command until the second word arrives and then issues the whole 32-bit command at once.

A one-bit pending flag tracks whether a first command word is being held. Any access to the data port clears the flag, and so does a read of the control port. Register writes, completed commands and data-port transfers come out as one-cycle strobes in the clock cycle after the host access. Host reads return the status word, the beam position or the data supplied from outside on `rdata_o` in that same following cycle. The register storage, the video memory and the counters are outside this block.

Top module: `vid_host_port`

## Requirements
- R1: An access hits the port window only when `(addr_i & 0xE700FF) >> 8` equals `0xC000`. Bits 20:19 and 15:8 of the address are therefore mirrors. Within the window, offsets 0x00-0x03 select the data port, 0x04-0x07 the control port, and 0x08-0x09 the position counter. Any other access gives no strobe and reads back 0.
- R2: A control write while no command is pending, with data bits 15:14 equal to binary 10, raises `reg_we_o` for one cycle. Data bits 12:8 appear on `reg_idx_o` and bits 7:0 on `reg_val_o`, and the pending flag stays clear.
- R3: Any other control write while no command is pending gives no strobe. It stores the word as the first command word and sets the pending flag.
- R4: A control write while a command is pending raises `cmd_valid_o` for one cycle, with the first word in bits 31:16 of `cmd_o` and the new word in bits 15:0. This holds whatever bits 15:14 of the new word are, and the pending flag is cleared.
- R5: A data-port write raises `data_wr_o` for one cycle with the word on `data_wdata_o`, and clears the pending flag.
- R6: A data-port read raises `data_rd_o` for one cycle and returns `data_rdata_i`. A control-port read returns `status_i`. Both clear the pending flag.
- R7: A word access at an odd address reads 0, and a write there is ignored. In both cases there is no strobe and the pending flag keeps its value. An odd byte read of the data port reads 0 and has no effect.
- R8: A byte write (`word_i`=0) uses `wdata_i[7:0]` copied into both halves of a word and is then handled as a word write at the same address. An odd byte write is therefore ignored.
- R9: A byte read at an even offset returns the high byte of the source in `rdata_o[7:0]`, and at an odd offset the low byte. The position counter word `hv_i` is vertical count high and horizontal count low. A word read at offset 0x08 returns `hv_i` whole.
- R10: Reset clears all strobes, `rdata_o` and the pending flag, so the first tagged control word after reset is a register write.
- R11: Every strobe lasts one cycle, at most one strobe is high in any cycle, and a cycle without `req_i` is followed by no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| addr_i | input | 24 | Host byte address |
| wdata_i | input | 16 | Write data (byte writes use bits 7:0) |
| status_i | input | 16 | Status word returned by control-port reads |
| hv_i | input | 16 | Vertical count (15:8) and horizontal count (7:0) |
| data_rdata_i | input | 16 | Word returned by data-port reads |
| rdata_o | output | 16 | Read data, valid the cycle after a read |
| reg_we_o | output | 1 | Register write strobe |
| reg_idx_o | output | 5 | Register index |
| reg_val_o | output | 8 | Register value |
| cmd_valid_o | output | 1 | Completed command strobe |
| cmd_o | output | 32 | First word (31:16) and second word (15:0) |
| data_wr_o | output | 1 | Data-port write strobe |
| data_wdata_o | output | 16 | Data-port write word |
| data_rd_o | output | 1 | Data-port read strobe |

## Verification
The hardest condition to reach from the ports is a pending flag that has been cleared through a side path, because the flag itself is never visible. The stimulus first stores a first command word. It then makes a clearing access, either a data write, a data read or a control read of word or byte size. Finally it sends a control word tagged as a register write. A register strobe proves the flag was cleared, while a command strobe would show it survived. The inverse case also appears: an odd-address access is placed between the two command words, and the completed command proves that access left the flag alone.

// File: rtl/vid_port_pkg.sv
package vid_port_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_HV   = 2'd3
  } port_sel_e;
endpackage

// File: rtl/vid_addr_dec.sv
module vid_addr_dec
  import vid_port_pkg::*;
#(
  parameter int unsigned          ADDR_W = 24,
  parameter logic [ADDR_W-1:0]    MASK   = 24'hE700FF,
  parameter logic [ADDR_W-1:0]    BASE   = 24'hC00000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output port_sel_e         sel_o,
  output logic              odd_o
);
  localparam int unsigned OFF_W = 8;

  logic [ADDR_W-1:0] masked;
  logic [OFF_W-1:0]  off;
  logic              hit;

  always_comb begin
    masked = addr_i & MASK;
    off    = masked[OFF_W-1:0];
    hit    = (masked[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W]);
    sel_o  = SEL_NONE;
    if (hit) begin
      if (off < 8'd4)                   sel_o = SEL_DATA;
      else if (off < 8'd8)              sel_o = SEL_CTRL;
      else if (off[OFF_W-1:1] == 7'd4)  sel_o = SEL_HV;
    end
    odd_o = addr_i[0];
  end
endmodule

// File: rtl/vid_ctrl_seq.sv
module vid_ctrl_seq #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned VAL_W  = 8,
  parameter logic [1:0]  REG_TAG = 2'b10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_ctrl_i,
  input  logic                clr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                reg_we_o,
  output logic [IDX_W-1:0]    reg_idx_o,
  output logic [VAL_W-1:0]    reg_val_o,
  output logic                cmd_valid_o,
  output logic [2*DATA_W-1:0] cmd_o,
  output logic                pend_o
);
  localparam int unsigned IDX_LO = DATA_W / 2;

  logic [DATA_W-1:0] first_q;
  logic              is_reg;

  assign is_reg = (wdata_i[DATA_W-1 -: 2] == REG_TAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o      <= 1'b0;
      first_q     <= '0;
      reg_we_o    <= 1'b0;
      reg_idx_o   <= '0;
      reg_val_o   <= '0;
      cmd_valid_o <= 1'b0;
      cmd_o       <= '0;
    end else begin
      reg_we_o    <= 1'b0;
      cmd_valid_o <= 1'b0;
      if (wr_ctrl_i) begin
        if (pend_o) begin
          cmd_valid_o <= 1'b1;
          cmd_o       <= {first_q, wdata_i};
          pend_o      <= 1'b0;
        end else if (is_reg) begin
          reg_we_o  <= 1'b1;
          reg_idx_o <= wdata_i[IDX_LO +: IDX_W];
          reg_val_o <= wdata_i[VAL_W-1:0];
        end else begin
          first_q <= wdata_i;
          pend_o  <= 1'b1;
        end
      end else if (clr_i) begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vid_read_mux.sv
module vid_read_mux
  import vid_port_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  port_sel_e         sel_i,
  input  logic              odd_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] hv_i,
  input  logic [DATA_W-1:0] data_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] nxt;
  logic              zero;

  always_comb begin
    unique case (sel_i)
      SEL_DATA: src = data_rdata_i;
      SEL_CTRL: src = status_i;
      SEL_HV:   src = hv_i;
      default:  src = '0;
    endcase
    // odd word reads and odd data-port byte reads return zero
    zero = (word_i && odd_i) || (sel_i == SEL_DATA && odd_i);
    if (zero)        nxt = '0;
    else if (word_i) nxt = src;
    else if (odd_i)  nxt = {{HALF{1'b0}}, src[HALF-1:0]};
    else             nxt = {{HALF{1'b0}}, src[DATA_W-1:HALF]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= nxt;
  end
endmodule

// File: rtl/vid_host_port.sv
module vid_host_port
  import vid_port_pkg::*;
#(
  parameter int unsigned       ADDR_W = 24,
  parameter int unsigned       DATA_W = 16,
  parameter int unsigned       IDX_W  = 5,
  parameter int unsigned       VAL_W  = 8,
  parameter logic [ADDR_W-1:0] MASK   = 24'hE700FF,
  parameter logic [ADDR_W-1:0] BASE   = 24'hC00000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                word_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W-1:0]   status_i,
  input  logic [DATA_W-1:0]   hv_i,
  input  logic [DATA_W-1:0]   data_rdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                reg_we_o,
  output logic [IDX_W-1:0]    reg_idx_o,
  output logic [VAL_W-1:0]    reg_val_o,
  output logic                cmd_valid_o,
  output logic [2*DATA_W-1:0] cmd_o,
  output logic                data_wr_o,
  output logic [DATA_W-1:0]   data_wdata_o,
  output logic                data_rd_o
);
  localparam int unsigned HALF = DATA_W / 2;

  port_sel_e         sel;
  logic              odd;
  logic              wr, rd;
  logic              wr_ctrl, wr_data, rd_data, rd_ctrl;
  logic [DATA_W-1:0] wword;
  logic              pend_q;

  vid_addr_dec #(.ADDR_W(ADDR_W), .MASK(MASK), .BASE(BASE)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel),
    .odd_o  (odd)
  );

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  // byte writes are widened and then follow the word path
  assign wword   = word_i ? wdata_i : {wdata_i[HALF-1:0], wdata_i[HALF-1:0]};
  assign wr_ctrl = wr && (sel == SEL_CTRL) && !odd;
  assign wr_data = wr && (sel == SEL_DATA) && !odd;
  assign rd_data = rd && (sel == SEL_DATA) && !odd;
  assign rd_ctrl = rd && (sel == SEL_CTRL) && !(word_i && odd);

  vid_ctrl_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W), .VAL_W(VAL_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ctrl_i   (wr_ctrl),
    .clr_i       (wr_data || rd_data || rd_ctrl),
    .wdata_i     (wword),
    .reg_we_o    (reg_we_o),
    .reg_idx_o   (reg_idx_o),
    .reg_val_o   (reg_val_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd_o),
    .pend_o      (pend_q)
  );

  vid_read_mux #(.DATA_W(DATA_W)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_i         (rd),
    .sel_i        (sel),
    .odd_i        (odd),
    .word_i       (word_i),
    .status_i     (status_i),
    .hv_i         (hv_i),
    .data_rdata_i (data_rdata_i),
    .rdata_o      (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_wr_o    <= 1'b0;
      data_rd_o    <= 1'b0;
      data_wdata_o <= '0;
    end else begin
      data_wr_o <= wr_data;
      data_rd_o <= rd_data;
      if (wr_data) data_wdata_o <= wword;
    end
  end
endmodule

// File: rtl/vid_host_port_chk.sv
module vid_host_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic we_i,
  input logic word_i,
  input logic odd_i,
  input logic pend_i,
  input logic reg_we_i,
  input logic cmd_valid_i,
  input logic data_wr_i,
  input logic data_rd_i
);
  logic any_strb;
  assign any_strb = reg_we_i || cmd_valid_i || data_wr_i || data_rd_i;

  // R11
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_i, cmd_valid_i, data_wr_i, data_rd_i}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !any_strb);

  // R4
  cmd_after_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> ($past(pend_i) && !pend_i));

  // R2
  reg_wr_nopend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> (!$past(pend_i) && !pend_i));

  // R3
  pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_i) |-> $past(req_i && we_i));

  // R7
  odd_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && word_i && odd_i) |=> (!any_strb && $stable(pend_i)));

  // R5
  data_wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i |-> !pend_i);
endmodule

bind vid_host_port vid_host_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .word_i      (word_i),
  .odd_i       (addr_i[0]),
  .pend_i      (pend_q),
  .reg_we_i    (reg_we_o),
  .cmd_valid_i (cmd_valid_o),
  .data_wr_i   (data_wr_o),
  .data_rd_i   (data_rd_o)
);

// File: tb/sim_vid_host_port.sv
`timescale 1ns/1ps
module sim_vid_host_port;
  typedef struct packed {
    logic        we;
    logic        word;
    logic [23:0] addr;
    logic [15:0] wd;
    logic [3:0]  strb;   // {reg_we, cmd_valid, data_wr, data_rd}
    logic [31:0] val;
    logic        chk_rd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,24'hC00004,16'h8F12,4'b1000,32'h00000F12,1'b0,4'd2},  // R2
    '{1'b1,1'b1,24'hC00004,16'h4000,4'b0000,32'h0,1'b0,4'd3},          // R3
    '{1'b1,1'b1,24'hC00006,16'h8123,4'b0100,32'h40008123,1'b0,4'd4},  // R4
    '{1'b1,1'b1,24'hC00000,16'hABCD,4'b0010,32'h0000ABCD,1'b0,4'd5},  // R5
    '{1'b1,1'b1,24'hC00004,16'h1234,4'b0000,32'h0,1'b0,4'd3},
    '{1'b1,1'b1,24'hC00002,16'h5555,4'b0010,32'h00005555,1'b0,4'd5},
    '{1'b1,1'b1,24'hC00004,16'h8A77,4'b1000,32'h00000A77,1'b0,4'd5},
    '{1'b1,1'b1,24'hC00004,16'hC001,4'b0000,32'h0,1'b0,4'd3},
    '{1'b0,1'b1,24'hC00004,16'h0000,4'b0000,32'h00003A5C,1'b1,4'd6},  // R6
    '{1'b1,1'b1,24'hC00004,16'h8B01,4'b1000,32'h00000B01,1'b0,4'd6},
    '{1'b1,1'b1,24'hC00004,16'h0002,4'b0000,32'h0,1'b0,4'd3},
    '{1'b0,1'b1,24'hC00000,16'h0000,4'b0001,32'h0000C3E1,1'b1,4'd6},
    '{1'b1,1'b1,24'hC00004,16'h9F00,4'b1000,32'h00001F00,1'b0,4'd6},
    '{1'b1,1'b1,24'hC00004,16'h2222,4'b0000,32'h0,1'b0,4'd3},
    '{1'b1,1'b1,24'hC00005,16'h8044,4'b0000,32'h0,1'b0,4'd7},          // R7
    '{1'b1,1'b1,24'hC00001,16'h7777,4'b0000,32'h0,1'b0,4'd7},
    '{1'b0,1'b1,24'hC00005,16'h0000,4'b0000,32'h0,1'b1,4'd7},
    '{1'b1,1'b1,24'hC00004,16'h8055,4'b0100,32'h22228055,1'b0,4'd4},
    '{1'b1,1'b1,24'hD8FF04,16'h8344,4'b1000,32'h00000344,1'b0,4'd1},  // R1
    '{1'b1,1'b1,24'hC10004,16'h8366,4'b0000,32'h0,1'b0,4'd1},
    '{1'b0,1'b1,24'hC10004,16'h0000,4'b0000,32'h0,1'b1,4'd1},
    '{1'b1,1'b0,24'hC00004,16'h1185,4'b1000,32'h00000585,1'b0,4'd8},  // R8
    '{1'b1,1'b0,24'hC00005,16'h0086,4'b0000,32'h0,1'b0,4'd8},
    '{1'b1,1'b0,24'hC00002,16'h003C,4'b0010,32'h00003C3C,1'b0,4'd8},
    '{1'b0,1'b0,24'hC00004,16'h0000,4'b0000,32'h0000003A,1'b1,4'd9},  // R9
    '{1'b0,1'b0,24'hC00007,16'h0000,4'b0000,32'h0000005C,1'b1,4'd9},
    '{1'b0,1'b0,24'hC00008,16'h0000,4'b0000,32'h0000007B,1'b1,4'd9},
    '{1'b0,1'b0,24'hC00009,16'h0000,4'b0000,32'h00000021,1'b1,4'd9},
    '{1'b0,1'b1,24'hC00008,16'h0000,4'b0000,32'h00007B21,1'b1,4'd9},
    '{1'b0,1'b0,24'hC00000,16'h0000,4'b0001,32'h000000C3,1'b1,4'd6},
    '{1'b0,1'b0,24'hC00001,16'h0000,4'b0000,32'h0,1'b1,4'd7},
    '{1'b1,1'b1,24'hC00004,16'h0003,4'b0000,32'h0,1'b0,4'd3},
    '{1'b0,1'b0,24'hC00005,16'h0000,4'b0000,32'h0000005C,1'b1,4'd6},
    '{1'b1,1'b1,24'hC00004,16'h8101,4'b1000,32'h00000101,1'b0,4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, word = 1'b1;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] status = 16'h3A5C, hv = 16'h7B21, drd = 16'hC3E1;
  logic [15:0] rdata;
  logic        reg_we, cmd_valid, data_wr, data_rd;
  logic [4:0]  reg_idx;
  logic [7:0]  reg_val;
  logic [31:0] cmd;
  logic [15:0] data_wdata;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  vid_host_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_i(word),
    .addr_i(addr), .wdata_i(wdata), .status_i(status), .hv_i(hv),
    .data_rdata_i(drd), .rdata_o(rdata), .reg_we_o(reg_we),
    .reg_idx_o(reg_idx), .reg_val_o(reg_val), .cmd_valid_o(cmd_valid),
    .cmd_o(cmd), .data_wr_o(data_wr), .data_wdata_o(data_wdata),
    .data_rd_o(data_rd)
  );

  function automatic logic [3:0] strb();
    return {reg_we, cmd_valid, data_wr, data_rd};
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    string rq;
    rq = $sformatf("R%0d", v.rq);
    @(negedge clk);
    req = 1'b1; we = v.we; word = v.word; addr = v.addr; wdata = v.wd;
    @(negedge clk);
    req = 1'b0;
    check(strb() == v.strb, rq, {28'h0, strb()}, {28'h0, v.strb});
    if (v.strb[3]) check({reg_idx, reg_val} == v.val[12:0], rq,
                         {19'h0, reg_idx, reg_val}, v.val);
    if (v.strb[2]) check(cmd == v.val, rq, cmd, v.val);
    if (v.strb[1]) check(data_wdata == v.val[15:0], rq,
                         {16'h0, data_wdata}, v.val);
    if (v.chk_rd)  check(rdata == v.val[15:0], rq, {16'h0, rdata}, v.val);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs at reset
    check(strb() == 4'b0 && rdata == 16'h0, "R10", {12'h0, strb(), rdata}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R11: strobe drops after one cycle, back-to-back
    @(negedge clk);
    req = 1'b1; we = 1'b1; word = 1'b1; addr = 24'hC00000; wdata = 16'h0F0F;
    @(negedge clk);
    req = 1'b0;
    check(data_wr == 1'b1, "R11", {31'h0, data_wr}, 32'h1);
    @(negedge clk);
    check(strb() == 4'b0, "R11", {28'h0, strb()}, 32'h0);

    // R10: reset while pending, then tagged word is a register write
    run_vec('{1'b1,1'b1,24'hC00004,16'h1000,4'b0000,32'h0,1'b0,4'd3});
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(strb() == 4'b0 && rdata == 16'h0, "R10", {12'h0, strb(), rdata}, 32'h0);
    rst_n = 1'b1;
    run_vec('{1'b1,1'b1,24'hC00004,16'h8234,4'b1000,32'h00000234,1'b0,4'd10});

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule